// File: doc/BRIEF.md
# Permissive-Gated Step Sequencer

This block controls one multi-step machine sequence. A start is accepted only when four conditions hold together: the continue permissive, the free-resource flag, a start-state condition that has been held steadily for a programmable number of cycles, and a request trigger. Once started, the block latches one step bit per cycle of progress. Step 1 latches first. Each later step waits for the step before it to be set and for that step's completion input. After the last step completes, a done flag latches.

While the continue permissive is low, nothing moves. The step bits hold their values, and progress resumes from the same place when the permissive returns. A per-step command is a plain combinational decode. It is high only while its step is the newest one set, the sequence is running and the permissive is present. A sequence clear pulse is raised when a running sequence has finished under the permissive, or at any time an abnormal-abort request arrives. That pulse wipes the running flag, the step vector and the done flag in one cycle.

Top module: `perm_step_seq`

## Requirements
- R1: A synchronous active-high `rst` clears running, done, all step bits and the qualification count, so every output reads zero after reset while the data inputs are low.
- R2: The start condition qualifies only once `start_raw` is high and the sequence is not running. This must hold for `qual_len` consecutive cycles. Any cycle without it restarts the count from zero, and `qual_len` = 0 qualifies in the same cycle.
- R3: `running` sets on the clock edge where `cont_ok`, `no_conflict`, `trigger` and the qualified start condition are all true while `running` is clear. It then stays set until a sequence clear.
- R4: Step 1 (bit 0 of `steps`) latches on the first edge at which `running` is set and `cont_ok` is high.
- R5: Step n+1 (bit n) latches only when bit n-1 is set and `step_cplt[n-1]` is high under `cont_ok`. Without the completion input the step vector does not change.
- R6: `done` latches when the last step bit is set, its completion input is high and `cont_ok` is high.
- R7: `seq_reset` is combinationally high when `cont_ok`, `running` and `done` are all high, or whenever `abort_req` is high.
- R8: While `cont_ok` is low, `running`, `steps` and `done` keep their values even if completion inputs are high. Progress continues from the same step when `cont_ok` returns.
- R9: `cmd[n]` is high only while `cont_ok` and `running` are high, step bit n is set and the next bit is clear. For the last step, `done` plays the role of the next bit. At most one command is high at a time.
- R10: A `seq_reset` pulse clears `running`, `done` and the whole step vector at the next edge, even when `cont_ok` is low. All commands are then zero.
- R11: With `trigger` and `start_raw` held high, a new start after a sequence clear requires the full `qual_len` qualification again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| cont_ok | input | 1 | Continue permissive |
| no_conflict | input | 1 | High when no other logic holds the shared resources |
| start_raw | input | 1 | Raw start-state condition before qualification |
| trigger | input | 1 | Start request event |
| step_cplt | input | N_STEPS | Completion input per step, bit n for step n+1 |
| abort_req | input | 1 | Abnormal clear request |
| qual_len | input | QUAL_W | Number of cycles the start condition must be held |
| running | output | 1 | Sequence active flag |
| steps | output | N_STEPS | Latched step bits, bit 0 is step 1 |
| done | output | 1 | Normal completion flag |
| seq_reset | output | 1 | Combinational sequence clear pulse |
| cmd | output | N_STEPS | Per-step command bits |

## Verification
The embedded properties assume the following about the inputs:
- All inputs are synchronous to `clk`.
- `qual_len` stays constant while a qualification is counting.
- `abort_req` may arrive at any cycle, with or without the permissive.

The directed bench respects these assumptions. It changes every input only a short time after a rising edge. It loads `qual_len` only while the system reset is held or the sequence is idle with the start condition low. It applies aborts both under the permissive and without it.

// File: rtl/pss_pkg.sv
package pss_pkg;

   localparam int unsigned MAX_STEPS = 32;
   localparam int unsigned MAX_QUAL_W = 32;

   // Start gate terms, all must be true together for a start.
   typedef struct packed {
      logic cont_ok;
      logic no_conflict;
      logic trigger;
      logic qualified;
      logic idle;
   } pss_gate_t;

   function automatic logic gate_open(input pss_gate_t g);
      return g.cont_ok & g.no_conflict & g.trigger & g.qualified & g.idle;
   endfunction

endpackage

// File: rtl/pss_qual_timer.sv
module pss_qual_timer #(
   parameter int unsigned QUAL_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_raw,
   input  logic              running,
   input  logic [QUAL_W-1:0] qual_len,
   output logic              qualified
);

   logic              cond;
   logic [QUAL_W-1:0] held_q;

   assign cond = start_raw & ~running;

   // Count consecutive cycles of the start condition and saturate at the limit.
   always_ff @(posedge clk) begin
      if (rst || !cond) begin
         held_q <= '0;
      end else if (held_q < qual_len) begin
         held_q <= held_q + 1'b1;
      end
   end

   assign qualified = cond & (held_q >= qual_len);

   // R2: a cycle without the condition restarts the count
   a_r2_restart: assert property (@(posedge clk) disable iff (rst)
      !cond |=> (!qualified || qual_len == '0));

endmodule

// File: rtl/pss_step_chain.sv
module pss_step_chain #(
   parameter int unsigned N_STEPS = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               cont_ok,
   input  logic               start_go,
   input  logic               seq_clear,
   input  logic [N_STEPS-1:0] step_cplt,
   output logic               running,
   output logic [N_STEPS-1:0] steps,
   output logic               done
);

   localparam int unsigned LAST = N_STEPS - 1;

   logic [N_STEPS-1:0] adv;
   logic               done_set;

   // Advance terms: the head step needs only running, the others need
   // their predecessor set and completed.
   for (genvar i = 0; i < N_STEPS; i++) begin : g_step
      if (i == 0) begin : g_head
         assign adv[i] = ~steps[0];
      end else begin : g_link
         assign adv[i] = ~steps[i] & steps[i-1] & step_cplt[i-1];
      end
   end

   assign done_set = steps[LAST] & step_cplt[LAST] & ~done;

   always_ff @(posedge clk) begin
      if (rst || seq_clear) begin
         running <= 1'b0;
         steps   <= '0;
         done    <= 1'b0;
      end else if (cont_ok) begin
         if (start_go) begin
            running <= 1'b1;
         end
         if (running) begin
            steps <= steps | adv;
            if (done_set) begin
               done <= 1'b1;
            end
         end
      end
   end

   // R8: no movement without the continue permissive
   a_r8_freeze: assert property (@(posedge clk) disable iff (rst)
      (!cont_ok && !seq_clear) |=> ($stable(steps) && $stable(done) && $stable(running)));

   // R10: a clear empties the whole sequence state
   a_r10_clear: assert property (@(posedge clk) disable iff (rst)
      seq_clear |=> (steps == '0 && !running && !done));

   // R5: step bits exist only inside a running sequence
   a_r5_idle_empty: assert property (@(posedge clk) disable iff (rst)
      !running |-> (steps == '0 && !done));

endmodule

// File: rtl/pss_cmd_decode.sv
module pss_cmd_decode #(
   parameter int unsigned N_STEPS = 8
) (
   input  logic               cont_ok,
   input  logic               running,
   input  logic [N_STEPS-1:0] steps,
   input  logic               done,
   output logic [N_STEPS-1:0] cmd
);

   logic [N_STEPS-1:0] nxt;

   for (genvar i = 0; i < N_STEPS; i++) begin : g_cmd
      if (i == N_STEPS - 1) begin : g_tail
         assign nxt[i] = done;
      end else begin : g_mid
         assign nxt[i] = steps[i+1];
      end
      assign cmd[i] = cont_ok & running & steps[i] & ~nxt[i];
   end

endmodule

// File: rtl/perm_step_seq.sv
module perm_step_seq #(
   parameter int unsigned N_STEPS = 8,
   parameter int unsigned QUAL_W  = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               cont_ok,
   input  logic               no_conflict,
   input  logic               start_raw,
   input  logic               trigger,
   input  logic [N_STEPS-1:0] step_cplt,
   input  logic               abort_req,
   input  logic [QUAL_W-1:0]  qual_len,
   output logic               running,
   output logic [N_STEPS-1:0] steps,
   output logic               done,
   output logic               seq_reset,
   output logic [N_STEPS-1:0] cmd
);

   import pss_pkg::*;

   localparam int unsigned LAST = N_STEPS - 1;

   if (N_STEPS < 1 || N_STEPS > MAX_STEPS) begin : g_bad_steps
      $error("perm_step_seq: N_STEPS out of range");
   end
   if (QUAL_W < 1 || QUAL_W > MAX_QUAL_W) begin : g_bad_qual
      $error("perm_step_seq: QUAL_W out of range");
   end

   logic      qualified;
   logic      start_go;
   pss_gate_t gate;

   pss_qual_timer #(.QUAL_W(QUAL_W)) i_qual (
      .clk       (clk),
      .rst       (rst),
      .start_raw (start_raw),
      .running   (running),
      .qual_len  (qual_len),
      .qualified (qualified)
   );

   assign gate.cont_ok     = cont_ok;
   assign gate.no_conflict = no_conflict;
   assign gate.trigger     = trigger;
   assign gate.qualified   = qualified;
   assign gate.idle        = ~running;
   assign start_go         = gate_open(gate);

   assign seq_reset = (cont_ok & running & done) | abort_req;

   pss_step_chain #(.N_STEPS(N_STEPS)) i_chain (
      .clk       (clk),
      .rst       (rst),
      .cont_ok   (cont_ok),
      .start_go  (start_go),
      .seq_clear (seq_reset),
      .step_cplt (step_cplt),
      .running   (running),
      .steps     (steps),
      .done      (done)
   );

   pss_cmd_decode #(.N_STEPS(N_STEPS)) i_cmd (
      .cont_ok (cont_ok),
      .running (running),
      .steps   (steps),
      .done    (done),
      .cmd     (cmd)
   );

   // R3: a start needs every permissive in the preceding cycle
   a_r3_start_gate: assert property (@(posedge clk) disable iff (rst)
      $rose(running) |-> $past(cont_ok && no_conflict && trigger && start_raw));

   // R6: done appears only after the last step completed
   a_r6_done_last: assert property (@(posedge clk) disable iff (rst)
      $rose(done) |-> (steps[LAST] && $past(step_cplt[LAST])));

   // R9: never two commands at once
   a_r9_cmd_onehot: assert property (@(posedge clk) disable iff (rst)
      $onehot0(cmd));

endmodule

// File: tb/test_perm_step_seq.sv
module test_perm_step_seq;

   localparam int N = 4;
   localparam int QW = 8;

   logic          clk = 1'b0;
   logic          rst;
   logic          cont_ok, no_conflict, start_raw, trigger, abort_req;
   logic [N-1:0]  step_cplt;
   logic [QW-1:0] qual_len;
   logic          running, done, seq_reset;
   logic [N-1:0]  steps, cmd;

   int n_vec = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   perm_step_seq #(.N_STEPS(N), .QUAL_W(QW)) i_perm_step_seq (
      .clk(clk), .rst(rst), .cont_ok(cont_ok), .no_conflict(no_conflict),
      .start_raw(start_raw), .trigger(trigger), .step_cplt(step_cplt),
      .abort_req(abort_req), .qual_len(qual_len), .running(running),
      .steps(steps), .done(done), .seq_reset(seq_reset), .cmd(cmd)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // One clock, then settle 2 ns past the edge for both drive and sample.
   task automatic cyc(input int n = 1);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic do_reset(input logic [QW-1:0] len);
      rst = 1'b1; cont_ok = 1'b0; no_conflict = 1'b0; start_raw = 1'b0;
      trigger = 1'b0; abort_req = 1'b0; step_cplt = '0; qual_len = len;
      cyc(2);
      rst = 1'b0;
      cyc(1);
   endtask

   task automatic t_reset_state;
      do_reset(8'd3);
      chk("R1 running", running, 0);
      chk("R1 steps", steps, 0);
      chk("R1 done/seq_reset", {done, seq_reset}, 0);
      chk("R1 cmd", cmd, 0);
   endtask

   // Full run with qualification, stalls, permissive loss and normal finish.
   task automatic t_full_run;
      do_reset(8'd3);
      cont_ok = 1; no_conflict = 1; trigger = 1; start_raw = 1;
      cyc(3);
      chk("R2 not yet qualified", running, 0);
      cyc(1);
      chk("R3 running set", running, 1);
      chk("R3 no step yet", steps, 0);
      cyc(1);
      chk("R4 step 1 latched", steps, 4'b0001);
      chk("R9 cmd step1", cmd, 4'b0001);
      cyc(3);
      chk("R5 waits for completion", steps, 4'b0001);
      step_cplt = 4'b0001;
      cyc(1);
      chk("R5 step 2 latched", steps, 4'b0011);
      chk("R9 cmd moves to step2", cmd, 4'b0010);
      cont_ok = 0; step_cplt = 4'b1111;
      #1;
      chk("R9 cmd drops without permissive", cmd, 0);
      cyc(3);
      chk("R8 steps frozen", steps, 4'b0011);
      chk("R8 running/done held", {running, done}, 2'b10);
      cont_ok = 1;
      #1;
      chk("R8 cmd resumes", cmd, 4'b0010);
      cyc(1);
      chk("R8 resumes at step3", steps, 4'b0111);
      cyc(1);
      chk("R9 last step cmd", cmd, 4'b1000);
      cyc(1);
      chk("R6 done latched", done, 1);
      chk("R9 last cmd ends on done", cmd, 0);
      chk("R7 seq_reset on done", seq_reset, 1);
      cyc(1);
      chk("R10 cleared", {running, done, steps}, 0);
      chk("R10 seq_reset released", seq_reset, 0);
      // trigger and start_raw still high: full qualification again
      cyc(3);
      chk("R11 requalifying", running, 0);
      cyc(1);
      chk("R11 restart after qual", running, 1);
   endtask

   task automatic t_abort_no_permissive;
      do_reset(8'd0);
      cont_ok = 1; no_conflict = 1; trigger = 1; start_raw = 1;
      cyc(1);
      chk("R2 zero length qualifies at once", running, 1);
      cyc(1);
      chk("R4 step1", steps, 4'b0001);
      cont_ok = 0; abort_req = 1;
      #1;
      chk("R7 abort raises seq_reset", seq_reset, 1);
      cyc(1);
      abort_req = 0; trigger = 0;
      chk("R10 abort clears without permissive", {running, done, steps}, 0);
      cont_ok = 1;
      #1;
      chk("R10 cmd zero after clear", cmd, 0);
   endtask

   task automatic t_qual_restart;
      do_reset(8'd3);
      cont_ok = 1; no_conflict = 1; trigger = 1; start_raw = 1;
      cyc(2);
      start_raw = 0;
      cyc(1);
      start_raw = 1;
      cyc(3);
      chk("R2 drop restarts count", running, 0);
      cyc(1);
      chk("R2 qualified after full hold", running, 1);
   endtask

   task automatic t_start_gates;
      do_reset(8'd0);
      cont_ok = 1; no_conflict = 0; trigger = 1; start_raw = 1;
      cyc(4);
      chk("R3 blocked by conflict", running, 0);
      no_conflict = 1; trigger = 0;
      cyc(4);
      chk("R3 blocked without trigger", running, 0);
      trigger = 1; cont_ok = 0;
      cyc(3);
      chk("R3 blocked without permissive", running, 0);
      cont_ok = 1;
      cyc(1);
      chk("R3 starts when all true", running, 1);
   endtask

   task automatic t_done_hold;
      do_reset(8'd0);
      cont_ok = 1; no_conflict = 1; trigger = 1; start_raw = 1; step_cplt = 4'b1111;
      cyc(5);
      chk("R5 all steps set", steps, 4'b1111);
      cont_ok = 0;
      cyc(1);
      chk("R8 done withheld", done, 0);
      cont_ok = 1;
      cyc(1);
      chk("R6 done sets", done, 1);
      cont_ok = 0;
      #1;
      chk("R7 no pulse without permissive", seq_reset, 0);
      cyc(2);
      chk("R8 done and running kept", {running, done}, 2'b11);
      cont_ok = 1;
      #1;
      chk("R7 pulse on return", seq_reset, 1);
      cyc(1);
      chk("R10 cleared after done", {running, done, steps}, 0);
   endtask

   initial begin
      t_reset_state();
      t_full_run();
      t_abort_no_permissive();
      t_qual_restart();
      t_start_gates();
      t_done_hold();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(20 * 100000);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule